// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

The block recovers characters from one asynchronous serial line. A baud-rate enable pulse arrives at 16 times the bit rate. The block looks for a falling edge on the idle-high line and confirms the start bit at its midpoint. It then samples each data bit at its centre, least significant bit first, followed by an optional parity bit and one, one and a half or two stop bits. The finished character goes into a holding register that the host reads. A one-cycle read-acknowledge pulse empties the holding register.

The character length, parity mode and stop length are runtime inputs. Parity, framing and overrun errors are reported as flags next to the character. An error never stops or resets the receiver. An interrupt request is raised whenever the holding register has something to report.

Top module: `serial_rx`

## Requirements
- R1: After reset, data_o is zero and valid_o, par_err_o, frm_err_o, ovr_err_o and irq_o are all low.
- R2: A start bit is accepted only if the line is still low when sampled half a bit time after the falling edge. A low pulse shorter than that produces no character.
- R3: cfg_len_i selects the data length: 0 selects 5 bits, 1 selects 6, 2 selects 7 and 3 selects 8. The first data bit received lands in data_o[0]. Bits of data_o above the selected length are zero.
- R4: cfg_par_i selects the parity mode: 0 or 1 means no parity bit, 2 means even and 3 means odd. par_err_o is set when the received parity bit and the ones in the data do not give the selected parity.
- R5: cfg_stop_i selects the stop length: 0 means one bit, 1 means one and a half bits, and 2 or 3 means two bits. A character is reported only after the last stop sample. With two stop bits, valid_o is still low at the end of the first stop bit.
- R6: frm_err_o is set when any stop sample reads low. The character is still delivered.
- R7: A character that completes while valid_o is high, with no acknowledge in the same cycle, replaces data_o and sets ovr_err_o.
- R8: valid_o and the error flags hold until rd_ack_i is high for a cycle, which clears all of them.
- R9: irq_o is high exactly when valid_o or any error flag is high.
- R10: After a character with an error, the next frame is received normally without any intervention.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling enable, 16 per bit time |
| rx_i | input | 1 | Serial line, idle high |
| cfg_len_i | input | 2 | Data length code (5 to 8 bits) |
| cfg_par_i | input | 2 | Parity mode code |
| cfg_stop_i | input | 2 | Stop length code |
| rd_ack_i | input | 1 | Host took the character |
| data_o | output | 8 | Received character, right aligned |
| valid_o | output | 1 | Holding register full |
| par_err_o | output | 1 | Parity error flag |
| frm_err_o | output | 1 | Framing error flag |
| ovr_err_o | output | 1 | Overrun error flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench uses the default oversampling of 16 and the two-stage input synchronizer, and pulses tick_i on every fourth clock. Because of this spacing, the synchronizer delay is smaller than one tick, so every sample point stays close to the bit centres the bench drives. The bench can then drive stop bits that are low for only part of their length. With these, the one-and-a-half-bit sample point and the resynchronisation after a framing error fall at predictable places in the frame. The bench sends frames with all four data lengths and all parity and stop modes, and it also sends short start glitches and back-to-back characters with no acknowledge between them.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
  import serial_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic [1:0]        len_i,
  input  logic [1:0]        par_i,
  input  logic [1:0]        stop_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              perr_o,
  output logic              ferr_o
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] HALF_M1 = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] FULL_M1 = CW'(OVS - 1);
  localparam logic [CW-1:0] TQ_M1   = CW'(OVS*3/4 - 1);

  rx_state_e         state_q;
  logic [CW-1:0]     cnt_q;
  logic [2:0]        bidx_q;
  logic [DATA_W-1:0] shreg_q;
  logic              pbit_q, ferr_q, sidx_q;
  logic              done_q, perr_q, ferr_out_q;

  logic          par_en, last_bit, need2, cnt_end;
  logic [CW-1:0] stop_lim;

  assign par_en   = par_i[1];
  assign need2    = (stop_i != 2'b00);
  assign last_bit = (bidx_q == {1'b1, len_i});
  // Second stop sample: 3/4 bit later for 1.5 stop bits, a full bit for 2
  assign stop_lim = (sidx_q && stop_i == 2'b01) ? TQ_M1 : FULL_M1;
  assign cnt_end  = (state_q == ST_STOP) ? (cnt_q == stop_lim) : (cnt_q == FULL_M1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      bidx_q     <= '0;
      shreg_q    <= '0;
      pbit_q     <= 1'b0;
      ferr_q     <= 1'b0;
      sidx_q     <= 1'b0;
      done_q     <= 1'b0;
      perr_q     <= 1'b0;
      ferr_out_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          ST_IDLE: begin
            if (!rx_i) begin
              state_q <= ST_START;
              cnt_q   <= '0;
            end
          end
          ST_START: begin
            if (cnt_q == HALF_M1) begin
              cnt_q <= '0;
              if (rx_i) begin
                state_q <= ST_IDLE;
              end else begin
                state_q <= ST_DATA;
                bidx_q  <= '0;
                shreg_q <= '0;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_DATA: begin
            if (cnt_end) begin
              cnt_q           <= '0;
              shreg_q[bidx_q] <= rx_i;
              if (last_bit) begin
                state_q <= par_en ? ST_PAR : ST_STOP;
                sidx_q  <= 1'b0;
                ferr_q  <= 1'b0;
              end else begin
                bidx_q <= bidx_q + 1'b1;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_PAR: begin
            if (cnt_end) begin
              cnt_q   <= '0;
              pbit_q  <= rx_i;
              state_q <= ST_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (cnt_end) begin
              cnt_q <= '0;
              if (!sidx_q && need2) begin
                sidx_q <= 1'b1;
                ferr_q <= !rx_i;
              end else begin
                state_q    <= ST_IDLE;
                done_q     <= 1'b1;
                ferr_out_q <= ferr_q | !rx_i;
                perr_q     <= par_en & (pbit_q ^ (^shreg_q) ^ par_i[0]);
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign done_o = done_q;
  assign data_o = shreg_q;
  assign perr_o = perr_q;
  assign ferr_o = ferr_out_q;
endmodule

// File: rtl/serial_rx_hold.sv
module serial_rx_hold
  import serial_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              perr_i,
  input  logic              ferr_i,
  input  logic              ack_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              perr_o,
  output logic              ferr_o,
  output logic              ovr_o,
  output logic              irq_o
);
  logic keep;
  assign keep = valid_o && !ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
      perr_o  <= 1'b0;
      ferr_o  <= 1'b0;
      ovr_o   <= 1'b0;
    end else if (done_i) begin
      data_o  <= data_i;
      valid_o <= 1'b1;
      perr_o  <= perr_i | (keep & perr_o);
      ferr_o  <= ferr_i | (keep & ferr_o);
      ovr_o   <= keep;
    end else if (ack_i) begin
      valid_o <= 1'b0;
      perr_o  <= 1'b0;
      ferr_o  <= 1'b0;
      ovr_o   <= 1'b0;
    end
  end

  assign irq_o = valid_o | perr_o | ferr_o | ovr_o;
endmodule

// File: rtl/serial_rx.sv
module serial_rx
  import serial_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic [1:0]        cfg_len_i,
  input  logic [1:0]        cfg_par_i,
  input  logic [1:0]        cfg_stop_i,
  input  logic              rd_ack_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              par_err_o,
  output logic              frm_err_o,
  output logic              ovr_err_o,
  output logic              irq_o
);
  logic              rx_s, done, perr, ferr;
  logic [DATA_W-1:0] fr_data;

  serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  serial_rx_frame #(.OVS(OVS)) u_frame (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .rx_i  (rx_s),
    .len_i (cfg_len_i),
    .par_i (cfg_par_i),
    .stop_i(cfg_stop_i),
    .done_o(done),
    .data_o(fr_data),
    .perr_o(perr),
    .ferr_o(ferr)
  );

  serial_rx_hold u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .done_i (done),
    .data_i (fr_data),
    .perr_i (perr),
    .ferr_i (ferr),
    .ack_i  (rd_ack_i),
    .data_o (data_o),
    .valid_o(valid_o),
    .perr_o (par_err_o),
    .ferr_o (frm_err_o),
    .ovr_o  (ovr_err_o),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rd_ack_i,
  input logic [7:0] data_o,
  input logic       valid_o,
  input logic       par_err_o,
  input logic       frm_err_o,
  input logic       ovr_err_o,
  input logic       irq_o
);
  // R8
  valid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !rd_ack_i |=> valid_o);

  // R8
  flag_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_err_o || frm_err_o || ovr_err_o) |-> valid_o);

  // R7
  ovr_needs_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |=> !ovr_err_o);

  // R7
  data_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !rd_ack_i |=> ($stable(data_o) || ovr_err_o));

  // R9
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !irq_o);
endmodule

bind serial_rx serial_rx_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rd_ack_i (rd_ack_i),
  .data_o   (data_o),
  .valid_o  (valid_o),
  .par_err_o(par_err_o),
  .frm_err_o(frm_err_o),
  .ovr_err_o(ovr_err_o),
  .irq_o    (irq_o)
);

// File: tb/serial_rx_tb_top.sv
module serial_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       rx_i = 1'b1;
  logic [1:0] cfg_len_i = 2'd3;
  logic [1:0] cfg_par_i = 2'd0;
  logic [1:0] cfg_stop_i = 2'd0;
  logic       rd_ack_i = 1'b0;
  logic [7:0] data_o;
  logic       valid_o, par_err_o, frm_err_o, ovr_err_o, irq_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  serial_rx dut_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .rx_i      (rx_i),
    .cfg_len_i (cfg_len_i),
    .cfg_par_i (cfg_par_i),
    .cfg_stop_i(cfg_stop_i),
    .rd_ack_i  (rd_ack_i),
    .data_o    (data_o),
    .valid_o   (valid_o),
    .par_err_o (par_err_o),
    .frm_err_o (frm_err_o),
    .ovr_err_o (ovr_err_o),
    .irq_o     (irq_o)
  );

  initial begin
    forever begin
      for (int i = 0; i < TICK_DIV; i++) begin
        @(negedge clk_i);
        tick_i = (i == TICK_DIV - 1);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold_line(input logic v, input int ticks);
    rx_i = v;
    repeat (ticks * TICK_DIV) @(negedge clk_i);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit bad_par,
                            input bit low1, input bit low2, input bit mid_chk);
    int n;
    logic [7:0] m;
    n = int'(cfg_len_i) + 5;
    m = 8'hFF >> (8 - n);
    hold_line(1'b0, 16);
    for (int i = 0; i < n; i++) hold_line(d[i], 16);
    if (cfg_par_i[1]) hold_line((^(d & m)) ^ cfg_par_i[0] ^ bad_par, 16);
    if (low1) begin hold_line(1'b0, 12); hold_line(1'b1, 4); end
    else hold_line(1'b1, 16);
    if (mid_chk) chk("R5 valid low before second stop", 32'(valid_o), 0);
    if (cfg_stop_i == 2'd1) hold_line(!low2, 8);
    else if (cfg_stop_i != 2'd0) begin
      if (low2) begin hold_line(1'b0, 12); hold_line(1'b1, 4); end
      else hold_line(1'b1, 16);
    end
    hold_line(1'b1, 16);
  endtask

  task automatic expect_char(input string tag, input logic [7:0] d,
                             input logic pe, input logic fe, input logic oe);
    chk({tag, " valid"}, 32'(valid_o), 1);
    chk({tag, " data"}, 32'(data_o), 32'(d));
    chk({tag, " par_err"}, 32'(par_err_o), 32'(pe));
    chk({tag, " frm_err"}, 32'(frm_err_o), 32'(fe));
    chk({tag, " ovr_err"}, 32'(ovr_err_o), 32'(oe));
    chk({tag, " R9 irq set"}, 32'(irq_o), 1);
    @(negedge clk_i) rd_ack_i = 1'b1;
    @(negedge clk_i) rd_ack_i = 1'b0;
    chk({tag, " R8 cleared"}, {28'd0, valid_o, par_err_o, frm_err_o, ovr_err_o}, 0);
    chk({tag, " R9 irq clear"}, 32'(irq_o), 0);
  endtask

  task automatic t_reset;
    chk("R1 reset outputs", {22'd0, data_o, valid_o, irq_o}, 0);
    chk("R1 reset flags", {29'd0, par_err_o, frm_err_o, ovr_err_o}, 0);
  endtask

  task automatic t_lengths;
    cfg_par_i = 2'd0; cfg_stop_i = 2'd0;
    cfg_len_i = 2'd3; send_frame(8'hA5, 0, 0, 0, 0); expect_char("R3 len8", 8'hA5, 0, 0, 0);
    cfg_len_i = 2'd0; send_frame(8'hF5, 0, 0, 0, 0); expect_char("R3 len5", 8'h15, 0, 0, 0);
    cfg_len_i = 2'd1; send_frame(8'hEA, 0, 0, 0, 0); expect_char("R3 len6", 8'h2A, 0, 0, 0);
    cfg_len_i = 2'd2; send_frame(8'hC1, 0, 0, 0, 0); expect_char("R3 len7", 8'h41, 0, 0, 0);
  endtask

  task automatic t_parity;
    cfg_stop_i = 2'd0;
    cfg_len_i = 2'd2; cfg_par_i = 2'd2;
    send_frame(8'h5B, 0, 0, 0, 0); expect_char("R4 even ok", 8'h5B, 0, 0, 0);
    cfg_len_i = 2'd3; cfg_par_i = 2'd3;
    send_frame(8'h37, 0, 0, 0, 0); expect_char("R4 odd ok", 8'h37, 0, 0, 0);
    cfg_len_i = 2'd1; cfg_par_i = 2'd2;
    send_frame(8'h2C, 1, 0, 0, 0); expect_char("R4 even bad", 8'h2C, 1, 0, 0);
    cfg_len_i = 2'd3; cfg_par_i = 2'd3;
    send_frame(8'h80, 1, 0, 0, 0); expect_char("R4 odd bad", 8'h80, 1, 0, 0);
  endtask

  task automatic t_stops;
    cfg_len_i = 2'd3; cfg_par_i = 2'd0;
    cfg_stop_i = 2'd1;
    send_frame(8'h3C, 0, 0, 0, 0); expect_char("R5 stop1.5", 8'h3C, 0, 0, 0);
    send_frame(8'hC3, 0, 0, 1, 0); expect_char("R6 stop1.5 half low", 8'hC3, 0, 1, 0);
    cfg_stop_i = 2'd2;
    send_frame(8'h69, 0, 0, 0, 1); expect_char("R5 stop2", 8'h69, 0, 0, 0);
    send_frame(8'h96, 0, 0, 1, 0); expect_char("R6 stop2 second low", 8'h96, 0, 1, 0);
  endtask

  task automatic t_frame_err;
    cfg_len_i = 2'd3; cfg_par_i = 2'd0; cfg_stop_i = 2'd0;
    send_frame(8'h11, 0, 1, 0, 0); expect_char("R6 stop1 low", 8'h11, 0, 1, 0);
    send_frame(8'h7E, 0, 0, 0, 0); expect_char("R10 resume", 8'h7E, 0, 0, 0);
  endtask

  task automatic t_overrun;
    cfg_len_i = 2'd3; cfg_par_i = 2'd2; cfg_stop_i = 2'd0;
    send_frame(8'hAA, 1, 0, 0, 0);
    send_frame(8'h55, 0, 0, 0, 0);
    expect_char("R7 overrun", 8'h55, 1, 0, 1);
  endtask

  task automatic t_glitch;
    cfg_len_i = 2'd3; cfg_par_i = 2'd0; cfg_stop_i = 2'd0;
    hold_line(1'b0, 3);
    hold_line(1'b1, 200);
    chk("R2 glitch ignored", 32'(valid_o), 0);
    chk("R2 glitch no irq", 32'(irq_o), 0);
    send_frame(8'h4D, 0, 0, 0, 0); expect_char("R2 start after glitch", 8'h4D, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    hold_line(1'b1, 20);
    t_lengths();
    t_parity();
    t_stops();
    t_frame_err();
    t_overrun();
    t_glitch();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule